// File: doc/BRIEF.md
# Serial Converter Command Bridge

The bridge sits between a processor's register interface and the serial control port of an analog-to-digital converter. Software writes 32-bit command words into a 15-entry command queue. Whenever a command is waiting, the read queue has room and the inter-frame pause has run out, the bridge pops one command and sends it as a 32-bit serial frame, most significant bit first. It advances one bit for each pulse of a serial clock enable. During the same frame it shifts in 32 bits from the converter's return line and files that word into a 15-entry read queue.

The converter answers with a one-frame delay. The word gathered during frame k is therefore the answer to command k-1, and the first frame after reset carries whatever the converter had pending. Every frame deposits a word, whether the command was a read, a write, a control or a no-op. Software discards the words that belong to non-read commands. When the last command of a burst is a read, one more command (a no-op does the job) must be sent to bring its answer back. Only the lower half of each returned word holds converter data. The bridge stores all 32 bits unchanged.

Both queues report empty, full and a fill level. Three sticky interrupt flags are provided, each with its own enable: command queue below a threshold, read queue at or above a threshold, and a command lost because the command queue was full. The interrupt line is the OR of the enabled flags.

Top module: `adc_cmd_bridge`

## Requirements
- R1: During and right after reset both queues are empty with level 0, intStatus is 0, irq is 0, frameActive is 0 and serOut is 0.
- R2: The command queue holds 15 words and raises cmdFull at level 15. A write while full is discarded, the level stays at 15, and intStatus bit 2 is set.
- R3: A frame drives the command on serOut MSB first, advancing one bit per serClkEn pulse, and holds frameActive high for the 32 pulses. It samples serIn on the same pulses, MSB first.
- R4: Every frame pushes exactly one word into the read queue, whatever the command is, and rdLevel counts the stored words.
- R5: The word stored after frame k is the one received during frame k, which is the converter's answer to command k-1. The first frame after reset stores the converter's pending dummy word.
- R6: A frame starts only when the command queue is not empty and the read queue holds fewer than 15 words. When rdLevel is 15, the bridge keeps frameActive low and the remaining commands wait.
- R7: Between the end of one frame and the start of the next, with a command waiting, exactly cfgGap serClkEn pulses pass with frameActive low.
- R8: rdData shows the oldest stored word, and a rdPopEn pulse removes it. A pop while the read queue is empty is ignored.
- R9: intStatus bit 0 is set while cmdLevel < cmdThresh, bit 1 while rdLevel >= rdThresh, and bit 2 on a lost write. The bits stay set until a one is pulsed on the matching intClear bit. A set condition that is present in the same cycle wins over the clear.
- R10: irq is high exactly when some intStatus bit and its intEnable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write strobe for the command queue |
| cmdWrData | input | 32 | Command word |
| rdPopEn | input | 1 | Remove the oldest read word |
| rdData | output | 32 | Oldest read word (show-ahead) |
| cfgGap | input | 4 | Pause between frames, in serClkEn pulses |
| serClkEn | input | 1 | Serial bit-rate enable |
| serOut | output | 1 | Serial command line |
| serIn | input | 1 | Serial return line |
| frameActive | output | 1 | High while a frame is being shifted |
| cmdEmpty | output | 1 | Command queue empty |
| cmdFull | output | 1 | Command queue full |
| cmdLevel | output | 4 | Command queue fill level |
| rdEmpty | output | 1 | Read queue empty |
| rdFull | output | 1 | Read queue full |
| rdLevel | output | 4 | Read queue fill level |
| cmdThresh | input | 4 | Low-water threshold of the command queue |
| rdThresh | input | 4 | High-water threshold of the read queue |
| intEnable | input | 3 | Interrupt enables |
| intClear | input | 3 | Write-one-to-clear pulses for intStatus |
| intStatus | output | 3 | Sticky interrupt flags |
| irq | output | 1 | Interrupt request |

## Verification
The converter model in the bench answers each command with its inverse. This exposes an off-by-one frame pairing, a lost dummy word, or a bit-order swap as a mismatch in the scoreboard. The bench stalls the serial clock and fills the command queue to 15 and beyond. A design that accepts a 16th word, or that misses the lost flag, shows up there. It also lets the read queue fill so that a bridge starting a frame without room would overwrite or drop a result. Finally, the bench counts the enable pulses in the pause for two settings, pops an empty read queue (an underflow would wrap the level), and pulses clear against a condition that is still true, which a clear-over-set design would lose.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;
  localparam int INT_W        = 3;
  localparam int INT_CMD_LOW  = 0;
  localparam int INT_RD_HIGH  = 1;
  localparam int INT_CMD_LOST = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} serState_t;

  typedef struct packed {
    logic load;   // pop a command into the shifter
    logic shift;  // advance one serial bit
    logic push;   // store the received word
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_bridge_datapath.sv
module adc_bridge_datapath
  import adc_bridge_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 15,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              rdPopEn,
  output logic [WORD_W-1:0] rdData,
  input  ctrlStrobes_t      strobe,
  input  logic              serIn,
  output logic              serOut,
  output logic [LVL_W-1:0]  cmdCnt,
  output logic [LVL_W-1:0]  rdCnt
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] cmdMem [DEPTH];
  logic [WORD_W-1:0] rdMem  [DEPTH];
  logic [PTR_W-1:0]  cmdWp, cmdRp, rdWp, rdRp;
  logic [WORD_W-1:0] txReg, rxReg, rxWord;
  logic              cmdPush, rdPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign cmdPush = cmdWrEn && (cmdCnt != FULL_LVL);
  assign rdPop   = rdPopEn && (rdCnt != '0);
  assign rxWord  = {rxReg[WORD_W-2:0], serIn};
  assign serOut  = txReg[WORD_W-1];
  assign rdData  = rdMem[rdRp];

  always_ff @(posedge clk) begin
    if (cmdPush) cmdMem[cmdWp] <= cmdWrData;
    if (strobe.push) rdMem[rdWp] <= rxWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWp <= '0; cmdRp <= '0; cmdCnt <= '0;
      rdWp  <= '0; rdRp  <= '0; rdCnt  <= '0;
      txReg <= '0; rxReg <= '0;
    end else begin
      if (cmdPush) cmdWp <= nextPtr(cmdWp);
      if (strobe.load) cmdRp <= nextPtr(cmdRp);
      case ({cmdPush, strobe.load})
        2'b10:   cmdCnt <= cmdCnt + 1'b1;
        2'b01:   cmdCnt <= cmdCnt - 1'b1;
        default: ;
      endcase
      if (strobe.push) rdWp <= nextPtr(rdWp);
      if (rdPop) rdRp <= nextPtr(rdRp);
      case ({strobe.push, rdPop})
        2'b10:   rdCnt <= rdCnt + 1'b1;
        2'b01:   rdCnt <= rdCnt - 1'b1;
        default: ;
      endcase
      if (strobe.load) begin
        txReg <= cmdMem[cmdRp];
        rxReg <= '0;
      end else if (strobe.shift) begin
        txReg <= txReg << 1;
        rxReg <= rxWord;
      end
    end
  end

  // R6: a word is only stored when the read queue has room
  a_r6_no_rd_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> rdCnt != FULL_LVL);
  // R2: command level never exceeds the depth
  a_r2_cmd_bound: assert property (@(posedge clk) disable iff (!rstN)
    cmdCnt <= FULL_LVL);
  // R8: popping an empty read queue leaves it empty
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    rdPopEn && rdCnt == '0 && !strobe.push |=> rdCnt == '0);
  // R3: the serial line only moves on a load or a shift
  a_r3_serout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load && !strobe.shift |=> $stable(serOut));
endmodule

// File: rtl/adc_bridge_ctrl.sv
module adc_bridge_ctrl
  import adc_bridge_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 15,
  parameter int GAP_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClkEn,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic [LVL_W-1:0] cmdLevel,
  input  logic [LVL_W-1:0] rdLevel,
  input  logic             cmdWrEn,
  input  logic [LVL_W-1:0] cmdThresh,
  input  logic [LVL_W-1:0] rdThresh,
  input  logic [INT_W-1:0] intEnable,
  input  logic [INT_W-1:0] intClear,
  output ctrlStrobes_t     strobe,
  output logic             frameActive,
  output logic [INT_W-1:0] intStatus,
  output logic             irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  serState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [INT_W-1:0] intSet;

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && (cmdLevel != '0) && (rdLevel != FULL_LVL);
    strobe.shift = (state == ST_SHIFT) && serClkEn;
    strobe.push  = strobe.shift && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      gapCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.load) begin
          state  <= ST_SHIFT;
          bitCnt <= '0;
        end
        ST_SHIFT: if (strobe.shift) begin
          bitCnt <= bitCnt + 1'b1;
          if (strobe.push) begin
            state  <= ST_GAP;
            gapCnt <= cfgGap;
          end
        end
        ST_GAP: begin
          if (gapCnt == '0) state <= ST_IDLE;
          else if (serClkEn) gapCnt <= gapCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign frameActive = (state == ST_SHIFT);

  always_comb begin
    intSet               = '0;
    intSet[INT_CMD_LOW]  = cmdLevel < cmdThresh;
    intSet[INT_RD_HIGH]  = rdLevel >= rdThresh;
    intSet[INT_CMD_LOST] = cmdWrEn && (cmdLevel == FULL_LVL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) intStatus <= '0;
    else       intStatus <= (intStatus & ~intClear) | intSet;
  end

  assign irq = |(intStatus & intEnable);

  // R7: no frame may start while pause pulses remain
  a_r7_gap_hold: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_GAP && gapCnt != '0 |=> !frameActive);
  // R9: flags not being cleared stay set
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (intStatus & $past(intStatus & ~intClear)) == $past(intStatus & ~intClear));
  // R3: without an enable pulse the frame does not advance
  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SHIFT && !serClkEn |=> state == ST_SHIFT && $stable(bitCnt));
  // R2: a write into a full queue raises the lost flag
  a_r2_lost_flag: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEn && cmdLevel == FULL_LVL |=> intStatus[INT_CMD_LOST]);
endmodule

// File: rtl/adc_cmd_bridge.sv
module adc_cmd_bridge
  import adc_bridge_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 15,
  parameter int GAP_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              rdPopEn,
  output logic [WORD_W-1:0] rdData,
  input  logic [GAP_W-1:0]  cfgGap,
  input  logic              serClkEn,
  output logic              serOut,
  input  logic              serIn,
  output logic              frameActive,
  output logic              cmdEmpty,
  output logic              cmdFull,
  output logic [LVL_W-1:0]  cmdLevel,
  output logic              rdEmpty,
  output logic              rdFull,
  output logic [LVL_W-1:0]  rdLevel,
  input  logic [LVL_W-1:0]  cmdThresh,
  input  logic [LVL_W-1:0]  rdThresh,
  input  logic [INT_W-1:0]  intEnable,
  input  logic [INT_W-1:0]  intClear,
  output logic [INT_W-1:0]  intStatus,
  output logic              irq
);
  ctrlStrobes_t strobe;

  adc_bridge_datapath #(.WORD_W(WORD_W), .DEPTH(DEPTH)) datapath_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .rdPopEn(rdPopEn), .rdData(rdData), .strobe(strobe), .serIn(serIn),
    .serOut(serOut), .cmdCnt(cmdLevel), .rdCnt(rdLevel)
  );

  adc_bridge_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .GAP_W(GAP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClkEn(serClkEn), .cfgGap(cfgGap),
    .cmdLevel(cmdLevel), .rdLevel(rdLevel), .cmdWrEn(cmdWrEn),
    .cmdThresh(cmdThresh), .rdThresh(rdThresh), .intEnable(intEnable),
    .intClear(intClear), .strobe(strobe), .frameActive(frameActive),
    .intStatus(intStatus), .irq(irq)
  );

  assign cmdEmpty = (cmdLevel == '0);
  assign cmdFull  = (cmdLevel == LVL_W'(DEPTH));
  assign rdEmpty  = (rdLevel == '0);
  assign rdFull   = (rdLevel == LVL_W'(DEPTH));
endmodule

// File: tb/adc_cmd_bridge_tb_top.sv
module adc_cmd_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DUMMY = 32'h5A5A_0F0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic rdPopEn = 1'b0;
  logic [31:0] rdData;
  logic [3:0] cfgGap = 4'd2;
  logic serClkEn = 1'b0;
  logic serOut;
  logic serIn = 1'b0;
  logic frameActive, cmdEmpty, cmdFull, rdEmpty, rdFull, irq;
  logic [3:0] cmdLevel, rdLevel;
  logic [3:0] cmdThresh = 4'd0;
  logic [3:0] rdThresh = 4'd15;
  logic [2:0] intEnable = '0;
  logic [2:0] intClear = '0;
  logic [2:0] intStatus;

  int checkCnt = 0;
  int failCnt = 0;
  logic [31:0] expRd[$];
  logic [31:0] expCmd[$];
  logic [31:0] prevResp = DUMMY;
  bit serEnOn = 1'b1;
  bit monitorOn = 1'b1;
  bit manualPop = 1'b0;

  // converter model state
  logic [31:0] respWord = DUMMY;
  logic [31:0] rxCmd = '0;
  int bitIdx = 0;
  bit inFrame = 1'b0;
  bit pendAdv = 1'b0;
  int divCnt = 0;
  int gapPulses = 0;
  int lastGap = -1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_cmd_bridge dut_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .rdPopEn(rdPopEn), .rdData(rdData), .cfgGap(cfgGap), .serClkEn(serClkEn),
    .serOut(serOut), .serIn(serIn), .frameActive(frameActive),
    .cmdEmpty(cmdEmpty), .cmdFull(cmdFull), .cmdLevel(cmdLevel),
    .rdEmpty(rdEmpty), .rdFull(rdFull), .rdLevel(rdLevel),
    .cmdThresh(cmdThresh), .rdThresh(rdThresh), .intEnable(intEnable),
    .intClear(intClear), .intStatus(intStatus), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // enable generator and converter model; the model answers a command with its inverse
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    serClkEn = serEnOn && (divCnt == 3);
    if (!frameActive && inFrame) begin
      inFrame = 1'b0;
      respWord = ~rxCmd;
      gapPulses = 0;
      if (expCmd.size() == 0) chk(1'b0, "R3 unexpected frame", rxCmd, 32'h0);
      else begin
        logic [31:0] e;
        e = expCmd.pop_front();
        chk(rxCmd == e, "R3 serial command bits", rxCmd, e);
      end
    end
    if (frameActive && !inFrame) begin
      inFrame = 1'b1;
      lastGap = gapPulses;
      bitIdx = 0;
      serIn = respWord[31];
    end else if (pendAdv && inFrame) begin
      bitIdx++;
      if (bitIdx < 32) serIn = respWord[31 - bitIdx];
    end
    pendAdv = 1'b0;
    if (frameActive && serClkEn) begin
      rxCmd = {rxCmd[30:0], serOut};
      pendAdv = 1'b1;
    end
    if (!frameActive && serClkEn) gapPulses++;
  end

  // scoreboard monitor on the read queue
  always @(negedge clk) begin
    if (monitorOn && !rdEmpty && rstN) begin
      if (expRd.size() == 0) chk(1'b0, "R4 unexpected read word", rdData, 32'h0);
      else begin
        logic [31:0] e;
        e = expRd.pop_front();
        chk(rdData == e, "R5 read word pairing", rdData, e);
      end
      rdPopEn = 1'b1;
    end else begin
      rdPopEn = manualPop;
    end
  end

  task automatic sendCmd(input logic [31:0] c, input bit dropped);
    @(negedge clk);
    cmdWrEn = 1'b1;
    cmdWrData = c;
    @(negedge clk);
    cmdWrEn = 1'b0;
    if (!dropped) begin
      expCmd.push_back(c);
      expRd.push_back(prevResp);
      prevResp = ~c;
    end
  endtask

  task automatic pulseClear(input logic [2:0] v);
    @(negedge clk);
    intClear = v;
    @(negedge clk);
    intClear = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmdEmpty && rdEmpty, "R1 empty flags", {cmdEmpty, rdEmpty}, 2'b11);
    chk(cmdLevel == 0 && rdLevel == 0, "R1 levels", {cmdLevel, rdLevel}, 0);
    chk(intStatus == 0 && !irq, "R1 interrupts", {intStatus, irq}, 0);
    chk(!frameActive && !serOut, "R1 serial idle", {frameActive, serOut}, 0);
    rstN = 1'b1;
    idle(4);
    chk(intStatus == 0 && !frameActive, "R1 after reset", {intStatus, frameActive}, 0);

    // R3 R5: pattern stream through the scoreboard
    sendCmd(32'h0000_0000, 0);
    sendCmd(32'hFFFF_FFFF, 0);
    sendCmd(32'hA5A5_0F0F, 0);
    sendCmd(32'h1234_5678, 0);
    sendCmd(32'h8000_0001, 0);
    sendCmd(32'h0000_0000, 0); // no-op flushes the previous answer
    idle(1200);
    chk(expRd.size() == 0, "R4 all words delivered", expRd.size(), 0);
    chk(expCmd.size() == 0, "R3 all frames sent", expCmd.size(), 0);

    // R4 one word per frame
    monitorOn = 0;
    sendCmd(32'h0BAD_F00D, 0);
    sendCmd(32'h7777_0000, 0);
    sendCmd(32'h0000_0000, 0);
    idle(600);
    chk(rdLevel == 3 && !rdEmpty, "R4 word count", rdLevel, 3);
    monitorOn = 1;
    idle(10);
    chk(rdEmpty, "R4 drained", rdLevel, 0);

    // R7 pause width
    cfgGap = 4'd3;
    sendCmd(32'h1111_2222, 0);
    sendCmd(32'h3333_4444, 0);
    idle(500);
    chk(lastGap == 3, "R7 gap of three", lastGap, 3);
    cfgGap = 4'd0;
    sendCmd(32'h5555_6666, 0);
    sendCmd(32'h7777_8888, 0);
    idle(400);
    chk(lastGap == 0, "R7 gap of zero", lastGap, 0);

    // R8 pop when empty is ignored, show-ahead data
    monitorOn = 0;
    idle(4);
    @(negedge clk); manualPop = 1'b1;
    @(negedge clk); manualPop = 1'b0;
    idle(2);
    chk(rdEmpty && rdLevel == 0, "R8 empty pop ignored", rdLevel, 0);
    sendCmd(32'hCAFE_0001, 0);
    idle(200);
    chk(rdLevel == 1, "R8 level after one frame", rdLevel, 1);
    chk(rdData == expRd[0], "R8 show-ahead data", rdData, expRd[0]);
    monitorOn = 1;
    idle(10);

    // R2 R6 full queues
    monitorOn = 0;
    serEnOn = 0;
    idle(10);
    sendCmd(32'hF000_0000, 0);
    idle(2);
    for (int i = 1; i < 16; i++) sendCmd(32'hF000_0000 | i, 0);
    chk(cmdFull && cmdLevel == 15, "R2 command queue full", cmdLevel, 15);
    sendCmd(32'hDEAD_DEAD, 1);
    idle(2);
    chk(cmdLevel == 15, "R2 write while full dropped", cmdLevel, 15);
    chk(intStatus[2], "R2 lost flag", intStatus, 3'b100);
    serEnOn = 1;
    idle(3000);
    chk(rdFull && rdLevel == 15, "R6 read queue full", rdLevel, 15);
    chk(cmdLevel == 1 && !frameActive, "R6 stall without room", {cmdLevel, frameActive}, 2);
    monitorOn = 1;
    idle(400);
    chk(rdEmpty && cmdEmpty, "R6 resumed and drained", {rdLevel, cmdLevel}, 0);
    rdThresh = 4'd15;
    pulseClear(3'b111);
    chk(intStatus == 0, "R9 clear all", intStatus, 0);

    // R9 R10 interrupts
    serEnOn = 0;
    monitorOn = 0;
    cmdThresh = 4'd3;
    idle(3);
    chk(intStatus[0], "R9 low-water set", intStatus, 3'b001);
    pulseClear(3'b001);
    chk(intStatus[0], "R9 set wins over clear", intStatus, 3'b001);
    intEnable = 3'b001;
    idle(1);
    chk(irq, "R10 enabled flag drives irq", irq, 1);
    sendCmd(32'h4000_0000, 0);
    idle(2);
    for (int i = 1; i < 5; i++) sendCmd(32'h4000_0000 | i, 0);
    pulseClear(3'b001);
    chk(!intStatus[0], "R9 clear when condition gone", intStatus, 3'b000);
    chk(!irq, "R10 irq follows clear", irq, 0);
    rdThresh = 4'd2;
    serEnOn = 1;
    idle(1500);
    chk(rdLevel == 5, "R4 five words", rdLevel, 5);
    chk(intStatus[1:0] == 2'b11, "R9 both thresholds", intStatus, 3'b011);
    intEnable = 3'b100;
    idle(1);
    chk(!irq, "R10 masked flags", irq, 0);
    intEnable = 3'b010;
    idle(1);
    chk(irq, "R10 high-water irq", irq, 1);
    intEnable = '0;
    monitorOn = 1;
    idle(50);
    cmdThresh = 4'd0;
    rdThresh = 4'd15;
    chk(expRd.size() == 0 && expCmd.size() == 0, "R5 scoreboard empty", expRd.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule